// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block keeps the interrupt presentation state of one processor. Its state is a 32-bit status word, with the processor's current priority in the top byte and the pending source number in the low 24 bits, plus two more registers. One holds the priority of the inter-processor interrupt (IPI). The other holds the priority of whatever is pending. A lower priority number means a more favoured interrupt. A single level output tells the processor that a source is waiting.

A source controller offers interrupts with a source number and a priority. The block either takes the offer and raises its output, or it refuses the offer with a reject pulse. When a more favoured offer displaces the pending source, the block also rejects the displaced source. The processor side issues four commands: write the current priority, write the IPI priority, accept, and end-of-interrupt (EOI). The IPI competes for the pending slot like any other source, under a reserved source number. Accept returns the status word in a read pulse. EOI sends a pulse carrying the finished source number back to the source controller. The block handles one event per clock. An offer from the source controller takes precedence over a processor command in the same cycle.

Top module: `intr_presenter`

## Requirements
- R1: After reset the status word is 0 (current priority 0x00, no source), the output is low, the IPI priority is 0xFF, the pending priority is 0xFF, and no reject, EOI or read pulse is given.
- R2: An offer whose priority is >= the current priority, or that arrives while a source is pending whose pending priority is <= the offer's priority, is refused. The cycle after the offer, rej_valid pulses with rej_src equal to the offered source, and the status word does not change.
- R3: Any other offer is taken. A non-zero pending source is rejected. The offered source and priority are installed, and irq_out is high the cycle after the offer.
- R4: Accept (cmd_op = 2) gives rd_valid in the next cycle, with rd_data equal to the status word as it was before the command. In the same step the output is lowered, the source field is cleared, and the current priority becomes the pending priority.
- R5: EOI (cmd_op = 3) gives eoi_valid in the next cycle, with eoi_src equal to cmd_data[23:0]. The current priority is loaded from cmd_data[31:24], and then a resend check runs: if the IPI priority is below the new current priority, the IPI check runs.
- R6: A current-priority write (cmd_op = 0, value in cmd_data[31:24]) that is more favoured than the current priority, made while a source is pending whose pending priority is >= the new value, clears the source field, lowers the output and rejects that source.
- R7: Any other more favoured current-priority write performs the resend check. A write that is not more favoured only changes the current priority.
- R8: An IPI priority write (cmd_op = 1, value in cmd_data[7:0]) stores the value. If the value is below the current priority, the IPI check runs; otherwise the pending state does not change.
- R9: The IPI check leaves the state alone when a source is pending whose pending priority is <= the IPI priority. Otherwise it rejects any pending source, installs the source number IPI_SRC (default 2) with the IPI priority as pending priority, and raises the output.
- R10: While req_valid is high, cmd_ready is low and a processor command offered in that cycle has no effect. The bench observes this at rd_valid, eoi_valid and the status word.
- R11: irq_out is high exactly when the source field of the status word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Offer from the source controller |
| req_src | input | 24 | Offered source number |
| req_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command valid |
| cmd_ready | output | 1 | Command is taken this cycle (no offer competing) |
| cmd_op | input | 2 | 0 current priority, 1 IPI priority, 2 accept, 3 EOI |
| cmd_data | input | 32 | Command operand |
| rd_valid | output | 1 | Accept result pulse |
| rd_data | output | 32 | Status word returned by accept |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source controller |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI pulse to the source controller |
| eoi_src | output | 24 | Source number being ended |
| cur_word | output | 32 | Status word: current priority and pending source |

## Verification
Two kinds of event can fall in the same cycle: an offer from the source controller and a processor command. The bench provokes this on purpose, first with an offer that lands together with an accept, and then many more times in a random phase where both inputs are driven independently. The outcome is judged against a behavioural model that applies only the offer. The bench then checks that no read pulse or EOI pulse appears, and that the status word matches the offer's outcome alone. A second collision is inside the block itself: an EOI or a priority write can trigger the IPI check, so an EOI pulse and a reject pulse can appear in the same cycle. The model predicts both pulses and the bench compares them separately.

// File: rtl/intp_pkg.sv
package intp_pkg;
  parameter int unsigned SRC_W  = 24;
  parameter int unsigned PRIO_W = 8;
  localparam int unsigned WORD_W = SRC_W + PRIO_W;

  localparam logic [1:0] OP_SET_CPPR = 2'd0;
  localparam logic [1:0] OP_SET_IPI  = 2'd1;
  localparam logic [1:0] OP_ACCEPT   = 2'd2;
  localparam logic [1:0] OP_EOI      = 2'd3;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PRESENT,
    EV_SET_CPPR,
    EV_SET_IPI,
    EV_ACCEPT,
    EV_EOI
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e            kind;
    logic [SRC_W-1:0]    src;
    logic [PRIO_W-1:0]   prio;
    logic [WORD_W-1:0]   data;
  } intp_event_t;
endpackage

// File: rtl/intp_arbiter.sv
module intp_arbiter
  import intp_pkg::*;
(
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              cmd_ready,
  output intp_event_t       ev
);
  // Offers from the source side always win; a command waits.
  always_comb begin
    cmd_ready = !req_valid;
    ev.src    = req_src;
    ev.prio   = req_prio;
    ev.data   = cmd_data;
    ev.kind   = EV_NONE;
    if (req_valid) begin
      ev.kind = EV_PRESENT;
    end else if (cmd_valid) begin
      unique case (cmd_op)
        OP_SET_CPPR: ev.kind = EV_SET_CPPR;
        OP_SET_IPI:  ev.kind = EV_SET_IPI;
        OP_ACCEPT:   ev.kind = EV_ACCEPT;
        default:     ev.kind = EV_EOI;
      endcase
    end
  end
endmodule

// File: rtl/intp_core.sv
module intp_core
  import intp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  intp_event_t       ev,
  output logic              irq_q,
  output logic [WORD_W-1:0] word_q,
  output logic              n_rej,
  output logic [SRC_W-1:0]  n_rej_src,
  output logic              n_eoi,
  output logic [SRC_W-1:0]  n_eoi_src,
  output logic              n_rd,
  output logic [WORD_W-1:0] n_rd_data
);
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;

  logic [PRIO_W-1:0] cppr_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic [PRIO_W-1:0] cppr_d, pend_d, ipi_d;
  logic [SRC_W-1:0]  src_d;
  logic              irq_d;
  logic              upd_en;
  logic              run_ipi;
  logic [PRIO_W-1:0] ipi_prio;
  logic [PRIO_W-1:0] new_cppr;
  logic              busy;

  assign busy   = (src_q != '0);
  assign upd_en = (ev.kind != EV_NONE);
  assign word_q = {cppr_q, src_q};

  always_comb begin
    cppr_d    = cppr_q;
    pend_d    = pend_q;
    ipi_d     = ipi_q;
    src_d     = src_q;
    irq_d     = irq_q;
    n_rej     = 1'b0;
    n_rej_src = '0;
    n_eoi     = 1'b0;
    n_eoi_src = '0;
    n_rd      = 1'b0;
    n_rd_data = '0;
    run_ipi   = 1'b0;
    ipi_prio  = ipi_q;
    new_cppr  = ev.data[WORD_W-1:SRC_W];

    unique case (ev.kind)
      EV_PRESENT: begin
        if ((ev.prio >= cppr_q) || (busy && (pend_q <= ev.prio))) begin
          n_rej     = 1'b1;
          n_rej_src = ev.src;
        end else begin
          if (busy) begin
            n_rej     = 1'b1;
            n_rej_src = src_q;
          end
          src_d  = ev.src;
          pend_d = ev.prio;
          irq_d  = 1'b1;
        end
      end
      EV_SET_CPPR: begin
        cppr_d = new_cppr;
        if (new_cppr < cppr_q) begin
          if (busy && (new_cppr <= pend_q)) begin
            n_rej     = 1'b1;
            n_rej_src = src_q;
            src_d     = '0;
            irq_d     = 1'b0;
          end else begin
            run_ipi = (ipi_q < new_cppr);
          end
        end
      end
      EV_SET_IPI: begin
        ipi_d    = ev.data[PRIO_W-1:0];
        ipi_prio = ev.data[PRIO_W-1:0];
        run_ipi  = (ev.data[PRIO_W-1:0] < cppr_q);
      end
      EV_ACCEPT: begin
        n_rd      = 1'b1;
        n_rd_data = {cppr_q, src_q};
        irq_d     = 1'b0;
        cppr_d    = pend_q;
        src_d     = '0;
      end
      EV_EOI: begin
        n_eoi     = 1'b1;
        n_eoi_src = ev.data[SRC_W-1:0];
        cppr_d    = new_cppr;
        run_ipi   = (ipi_q < new_cppr);
      end
      default: ;
    endcase

    // IPI competes for the pending slot as a pseudo-source.
    if (run_ipi && !(busy && (pend_q <= ipi_prio))) begin
      if (busy) begin
        n_rej     = 1'b1;
        n_rej_src = src_q;
      end
      src_d  = IPI_SRC;
      pend_d = ipi_prio;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      pend_q <= PRIO_LEAST;
      ipi_q  <= PRIO_LEAST;
      src_q  <= '0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      cppr_q <= cppr_d;
      pend_q <= pend_d;
      ipi_q  <= ipi_d;
      src_q  <= src_d;
      irq_q  <= irq_d;
    end
  end

  assert_irq_tracks_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (src_q != '0));

  assert_refused_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.kind == EV_PRESENT) && (ev.prio >= cppr_q)
    |=> $stable(src_q) && $stable(cppr_q));

  assert_taken_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.kind == EV_PRESENT) && (ev.prio < cppr_q) && (!busy || (pend_q > ev.prio))
    |=> irq_q && (src_q == $past(ev.src)));

  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.kind == EV_ACCEPT) |=> (src_q == '0) && !irq_q && (cppr_q == $past(pend_q)));

  assert_ipi_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.kind == EV_SET_IPI) && (ev.data[PRIO_W-1:0] >= cppr_q) |=> $stable(src_q));
endmodule

// File: rtl/intp_notify.sv
module intp_notify
  import intp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              n_rej,
  input  logic [SRC_W-1:0]  n_rej_src,
  input  logic              n_eoi,
  input  logic [SRC_W-1:0]  n_eoi_src,
  input  logic              n_rd,
  input  logic [WORD_W-1:0] n_rd_data,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_valid <= 1'b0;
      rej_src   <= '0;
      eoi_valid <= 1'b0;
      eoi_src   <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rej_valid <= n_rej;
      rej_src   <= n_rej_src;
      eoi_valid <= n_eoi;
      eoi_src   <= n_eoi_src;
      rd_valid  <= n_rd;
      rd_data   <= n_rd_data;
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import intp_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_out,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic [WORD_W-1:0] cur_word
);
  intp_event_t       ev;
  logic              n_rej, n_eoi, n_rd;
  logic [SRC_W-1:0]  n_rej_src, n_eoi_src;
  logic [WORD_W-1:0] n_rd_data;

  intp_arbiter u_arb (
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_prio  (req_prio),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .ev        (ev)
  );

  intp_core #(.IPI_SRC(IPI_SRC)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev),
    .irq_q     (irq_out),
    .word_q    (cur_word),
    .n_rej     (n_rej),
    .n_rej_src (n_rej_src),
    .n_eoi     (n_eoi),
    .n_eoi_src (n_eoi_src),
    .n_rd      (n_rd),
    .n_rd_data (n_rd_data)
  );

  intp_notify u_notify (
    .clk       (clk),
    .rst_n     (rst_n),
    .n_rej     (n_rej),
    .n_rej_src (n_rej_src),
    .n_eoi     (n_eoi),
    .n_eoi_src (n_eoi_src),
    .n_rd      (n_rd),
    .n_rd_data (n_rd_data),
    .rej_valid (rej_valid),
    .rej_src   (rej_src),
    .eoi_valid (eoi_valid),
    .eoi_src   (eoi_src),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assert_eoi_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !req_valid && (cmd_op == OP_EOI)
    |=> eoi_valid && (eoi_src == $past(cmd_data[SRC_W-1:0])));

  assert_offer_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cmd_valid |=> !rd_valid && !eoi_valid);

  assert_accept_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !req_valid && (cmd_op == OP_ACCEPT)
    |=> rd_valid && (rd_data == $past(cur_word)));
endmodule

// File: tb/intr_presenter_test.sv
`timescale 1ns/1ps
module intr_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_src;
  logic [7:0]  req_prio;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_out;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic [31:0] cur_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int unsigned m_cppr, m_src, m_pend, m_mfrr;
  bit m_irq;
  bit e_rej, e_eoi, e_rdv;
  int unsigned e_rejsrc, e_eoisrc, e_rd;

  always #4 clk = ~clk;

  intr_presenter uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .cur_word(cur_word)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3/R6 status word", cur_word, {m_cppr[7:0], m_src[23:0]});
    chk("R11 irq_out", irq_out, m_irq);
    chk("R2/R3 reject pulse", rej_valid, e_rej);
    if (e_rej) chk("R2/R9 reject source", rej_src, e_rejsrc);
    chk("R5 eoi pulse", eoi_valid, e_eoi);
    if (e_eoi) chk("R5 eoi source", eoi_src, e_eoisrc);
    chk("R4 read pulse", rd_valid, e_rdv);
    if (e_rdv) chk("R4 read data", rd_data, e_rd);
  endtask

  task automatic model_step(bit rv, int unsigned rs, int unsigned rp,
                            bit cv, int unsigned op, logic [31:0] d);
    bit do_ipi = 0;
    int unsigned ip = m_mfrr;
    int unsigned nc;
    e_rej = 0; e_eoi = 0; e_rdv = 0;
    if (rv) begin
      if (rp >= m_cppr || (m_src != 0 && m_pend <= rp)) begin
        e_rej = 1; e_rejsrc = rs;
      end else begin
        if (m_src != 0) begin e_rej = 1; e_rejsrc = m_src; end
        m_src = rs; m_pend = rp; m_irq = 1;
      end
    end else if (cv) begin
      case (op)
        0: begin
          nc = d[31:24];
          if (nc < m_cppr) begin
            if (m_src != 0 && nc <= m_pend) begin
              e_rej = 1; e_rejsrc = m_src; m_src = 0; m_irq = 0;
            end else do_ipi = (m_mfrr < nc);
          end
          m_cppr = nc;
        end
        1: begin
          m_mfrr = d[7:0]; ip = m_mfrr; do_ipi = (m_mfrr < m_cppr);
        end
        2: begin
          e_rdv = 1; e_rd = (m_cppr << 24) | m_src;
          m_irq = 0; m_cppr = m_pend; m_src = 0;
        end
        default: begin
          e_eoi = 1; e_eoisrc = d[23:0];
          m_cppr = d[31:24]; do_ipi = (m_mfrr < m_cppr);
        end
      endcase
    end
    if (do_ipi && !(m_src != 0 && m_pend <= ip)) begin
      if (m_src != 0) begin e_rej = 1; e_rejsrc = m_src; end
      m_src = 2; m_pend = ip; m_irq = 1;
    end
  endtask

  // One clock: compare the outputs of the previous step, then drive the next stimulus
  task automatic cycle(bit rv, int unsigned rs, int unsigned rp,
                       bit cv, int unsigned op, logic [31:0] d);
    @(negedge clk);
    compare_all();
    req_valid = rv; req_src = rs[23:0]; req_prio = rp[7:0];
    cmd_valid = cv; cmd_op = op[1:0]; cmd_data = d;
    #1;
    if (rv && cv) chk("R10 cmd_ready low", cmd_ready, 0);
    model_step(rv, rs, rp, cv, op, d);
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 32'h0);
  endtask

  function automatic int unsigned pick_prio();
    int unsigned r = $urandom_range(0, 7);
    case (r)
      0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 5; 5: return 8; 6: return 8'hFF;
      default: return $urandom_range(0, 255);
    endcase
  endfunction

  initial begin
    rst_n = 0; req_valid = 0; req_src = 0; req_prio = 0;
    cmd_valid = 0; cmd_op = 0; cmd_data = 0;
    m_cppr = 0; m_src = 0; m_pend = 8'hFF; m_mfrr = 8'hFF; m_irq = 0;
    e_rej = 0; e_eoi = 0; e_rdv = 0; e_rejsrc = 0; e_eoisrc = 0; e_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state at the ports
    chk("R1 reset word", cur_word, 32'h0);
    chk("R1 reset irq", irq_out, 0);
    chk("R1 reset pulses", {rej_valid, eoi_valid, rd_valid}, 0);
    chk("R1 cmd_ready idle", cmd_ready, 1);

    cycle(0, 0, 0, 1, 0, 32'hFF00_0000);      // R7: less favoured write
    idle(); chk("R7 plain cppr write", cur_word, 32'hFF00_0000);
    cycle(1, 24'h10, 5, 0, 0, 0);             // R3 take
    idle(); chk("R3 installed", cur_word, 32'hFF00_0010); chk("R3 irq high", irq_out, 1);
    cycle(1, 24'h11, 5, 0, 0, 0);             // R2 equal priority refused
    idle(); chk("R2 refused source", rej_src, 24'h11); chk("R2 word kept", cur_word, 32'hFF00_0010);
    cycle(1, 24'h12, 3, 0, 0, 0);             // R3 displace
    idle(); chk("R3 displaced reject", rej_src, 24'h10);
    cycle(0, 0, 0, 1, 1, 32'h4);              // R9 IPI loses to pending 3
    idle(); chk("R9 IPI held off", cur_word, 32'hFF00_0012);
    cycle(0, 0, 0, 1, 1, 32'h1);              // R8/R9 IPI wins
    idle(); chk("R8 IPI installed", cur_word, 32'hFF00_0002); chk("R9 reject old", rej_src, 24'h12);
    cycle(0, 0, 0, 1, 2, 0);                  // R4 accept
    idle(); chk("R4 accept data", rd_data, 32'hFF00_0002); chk("R4 word after", cur_word, 32'h0100_0000);
    cycle(1, 24'h20, 0, 0, 0, 0);
    cycle(0, 0, 0, 1, 0, 32'h0);              // R6 evict
    idle(); chk("R6 evicted", cur_word, 32'h0); chk("R6 reject evicted", rej_src, 24'h20);
    cycle(0, 0, 0, 1, 3, 32'hFF00_0002);      // R5 EOI + resend
    idle(); chk("R5 eoi src", eoi_src, 24'h2); chk("R5 resend IPI", cur_word, 32'hFF00_0002);
    cycle(1, 24'h30, 0, 1, 2, 0);             // R10 collision, accept ignored
    idle(); chk("R10 no read pulse", rd_valid, 0); chk("R10 offer applied", cur_word, 32'hFF00_0030);
    cycle(0, 0, 0, 1, 0, 32'h8000_0000);      // R7 favoured write, no eviction
    idle(); chk("R7 resend keeps", cur_word, 32'h8000_0030);

    for (int i = 0; i < 4000; i++) begin
      bit rv = ($urandom_range(0, 9) < 3);
      bit cv = ($urandom_range(0, 9) < 5);
      int unsigned op = $urandom_range(0, 3);
      int unsigned pr = pick_prio();
      logic [31:0] d;
      d = {pick_prio()[7:0], 24'($urandom_range(0, 40))};
      if (op == 1) d = {24'h0, pr[7:0]};
      cycle(rv, $urandom_range(3, 60), pick_prio(), cv, op, d);
    end
    idle();
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule